// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Sequencer

This block sits between a clocked host and an external 128K x 8 asynchronous static RAM. It accepts one single-byte command at a time through a valid/ready handshake and turns it into the address, chip-select, write-strobe, output-strobe and data-bus sequence the RAM needs. Read data comes back to the host as a one-cycle response pulse with the captured byte.

Every analog timing limit of the RAM (write pulse width, data setup, output float time after the write strobe falls, access time, cycle time) is given as a nanosecond parameter. It is turned into a whole number of clock cycles by rounding up against the clock period parameter. Writes are framed by the write strobe while the output strobe stays high. The data drivers switch on only after the RAM's outputs have had time to float. An idle cycle is placed between a write and a read that follow each other in either order. Between commands the RAM is deselected so that it sits in standby.

The data bus is presented as three separate signals: an outgoing byte, a drive enable and an incoming byte. A pad ring or bench model resolves them onto the shared wires.

Top module: `sram_async_ctl`

## Requirements
- R1: The RAM counts as selected only when `mem_ce_n` is 0 and `mem_ce` is 1. Whenever `req_ready` is 1 (idle), `mem_ce_n` is 1 and `mem_ce` is 0, so the RAM is in standby.
- R2: During a write, `mem_oe_n` stays 1. Address and selection are valid one cycle before `mem_we_n` falls. `mem_addr` does not change while the RAM stays selected.
- R3: `mem_dq_oe` rises only after `mem_we_n` has been low for at least ceil(20 ns / clock period) cycles, which is 5 cycles at 4 ns. The drivers are never on while `mem_oe_n` is 0.
- R4: `mem_we_n` stays low for at least ceil(40 ns / period) cycles. The byte is driven for at least ceil(25 ns / period) cycles before `mem_we_n` rises, and it stays driven for the cycle in which `mem_we_n` rises.
- R5: A write keeps the controller busy (`req_ready` 0) for at least ceil(55 ns / period) cycles, which is 14 cycles at 4 ns when no turnaround is needed.
- R6: A read holds `mem_oe_n` at 0 and `mem_we_n` at 1 for ceil(55 ns / period) cycles, which is 14 at 4 ns. The bus is sampled at the end of that window. `rsp_valid` is 1 for exactly the next cycle, with the byte on `rsp_rdata`. Writes produce no `rsp_valid`.
- R7: A command whose direction (`req_write`) differs from the previous accepted command gets one extra idle cycle before selection. A command in the same direction, or the first after reset, is selected in the cycle right after acceptance.
- R8: A command is accepted at a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 1 only in the idle state. With `req_valid` at 0 the controller stays idle.
- R9: While `rst` is 1 and after it is released: `req_ready` 1, `rsp_valid` 0, `mem_ce_n` 1, `mem_ce` 0, `mem_we_n` 1, `mem_oe_n` 1, `mem_dq_oe` 0.
- R10: A read returns the byte most recently written to the same address, for any 17-bit address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Host command valid |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | One-cycle read-data pulse |
| rsp_rdata | output | 8 | Read byte |
| mem_addr | output | 17 | RAM address bus |
| mem_ce_n | output | 1 | RAM select, active low |
| mem_ce | output | 1 | RAM select, active high |
| mem_we_n | output | 1 | RAM write strobe, active low |
| mem_oe_n | output | 1 | RAM output strobe, active low |
| mem_dq_out | output | 8 | Byte driven onto the data bus |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_in | input | 8 | Byte read from the data bus |

## Verification
The hardest thing to observe from the ports is an early sample or an early drive, because the host only sees a byte. The bench therefore uses a RAM model that returns the inverse of the stored byte until the full access time has elapsed at a stable address. A register that samples even one cycle early hands back a visibly wrong byte. The same model times the write strobe, the drive window and the overlap of drivers with the RAM's own outputs on every write. It counts every violation, and that count is checked at the end. Alternating table entries force each direction change in both orders, and the cycle of first selection is compared against the expected turnaround.

// File: rtl/sram_ctl_pkg.sv
`timescale 1ns/1ps
package sram_ctl_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_TURN,
        ST_W_SEL,
        ST_W_FLOAT,
        ST_W_DRIVE,
        ST_W_HOLD,
        ST_W_RECOV,
        ST_R_ACC
    } seq_state_e;

    // Active-high internal view of the pin strobes
    typedef struct packed {
        logic sel;
        logic we;
        logic oe;
        logic drv;
    } strobe_t;

    function automatic int cdiv(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_timer.sv
`timescale 1ns/1ps
module sram_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/sram_seq.sv
`timescale 1ns/1ps
module sram_seq
    import sram_ctl_pkg::*;
#(
    parameter int CLK_NS    = 4,
    parameter int T_WC_NS   = 55,
    parameter int T_WP_NS   = 40,
    parameter int T_CW_NS   = 40,
    parameter int T_DS_NS   = 25,
    parameter int T_HZWE_NS = 20,
    parameter int T_RC_NS   = 55,
    parameter int T_AA_NS   = 55,
    parameter int T_OE_NS   = 25
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    req_valid,
    input  logic    req_write,
    output logic    req_ready,
    output logic    accept,
    output logic    sample,
    output strobe_t strb
);
    localparam int HZ_C   = imax(1, cdiv(T_HZWE_NS, CLK_NS));
    localparam int WP_C   = cdiv(T_WP_NS, CLK_NS);
    localparam int CW_C   = cdiv(T_CW_NS, CLK_NS);
    localparam int DS_C   = cdiv(T_DS_NS, CLK_NS);
    localparam int WC_C   = cdiv(T_WC_NS, CLK_NS);
    localparam int DRV_C  = imax(1, imax(DS_C, imax(WP_C - HZ_C, CW_C - 1 - HZ_C)));
    localparam int BASE_C = 2 + HZ_C + DRV_C;
    localparam int REC_C  = (WC_C > BASE_C) ? (WC_C - BASE_C) : 0;
    localparam int ACC_C  = imax(1, imax(cdiv(T_AA_NS, CLK_NS),
                                 imax(cdiv(T_RC_NS, CLK_NS), cdiv(T_OE_NS, CLK_NS))));
    localparam int MAX_C  = imax(imax(HZ_C, DRV_C), imax(REC_C, ACC_C));
    localparam int CNT_W  = $clog2(MAX_C + 1);
    localparam int RUN_W  = $clog2(HZ_C + DRV_C + 2);

    seq_state_e       state, state_nx;
    logic             pend_write, last_write, have_last;
    logic             tmr_load, tmr_done;
    logic [CNT_W-1:0] tmr_val;

    sram_timer #(.W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    always_comb begin
        state_nx  = state;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        accept    = 1'b0;
        sample    = 1'b0;
        req_ready = (state == ST_IDLE);
        unique case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    accept = 1'b1;
                    if (have_last && (req_write != last_write))
                        state_nx = ST_TURN;
                    else if (req_write)
                        state_nx = ST_W_SEL;
                    else begin
                        state_nx = ST_R_ACC;
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(ACC_C - 1);
                    end
                end
            end
            ST_TURN: begin
                if (pend_write)
                    state_nx = ST_W_SEL;
                else begin
                    state_nx = ST_R_ACC;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(ACC_C - 1);
                end
            end
            ST_W_SEL: begin
                state_nx = ST_W_FLOAT;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(HZ_C - 1);
            end
            ST_W_FLOAT: begin
                if (tmr_done) begin
                    state_nx = ST_W_DRIVE;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(DRV_C - 1);
                end
            end
            ST_W_DRIVE: begin
                if (tmr_done)
                    state_nx = ST_W_HOLD;
            end
            ST_W_HOLD: begin
                if (REC_C > 0) begin
                    state_nx = ST_W_RECOV;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(REC_C - 1);
                end else
                    state_nx = ST_IDLE;
            end
            ST_W_RECOV: begin
                if (tmr_done)
                    state_nx = ST_IDLE;
            end
            ST_R_ACC: begin
                if (tmr_done) begin
                    sample   = 1'b1;
                    state_nx = ST_IDLE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            pend_write <= 1'b0;
            last_write <= 1'b0;
            have_last  <= 1'b0;
        end else begin
            state <= state_nx;
            if (accept) begin
                pend_write <= req_write;
                last_write <= req_write;
                have_last  <= 1'b1;
            end
        end
    end

    always_comb begin
        strb.sel = (state inside {ST_W_SEL, ST_W_FLOAT, ST_W_DRIVE, ST_W_HOLD, ST_R_ACC});
        strb.we  = (state inside {ST_W_FLOAT, ST_W_DRIVE});
        strb.drv = (state inside {ST_W_DRIVE, ST_W_HOLD});
        strb.oe  = (state == ST_R_ACC);
    end

    // Cycles the write strobe has been low before the current cycle
    logic [RUN_W-1:0] we_run;
    always_ff @(posedge clk) begin
        if (rst || !strb.we)
            we_run <= '0;
        else if (we_run != '1)
            we_run <= we_run + 1'b1;
    end

    logic drv_w, we_w;
    assign drv_w = strb.drv;
    assign we_w  = strb.we;

    AST_READY_STANDBY: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !strb.sel);                                   // R1
    AST_DRIVE_AFTER_FLOAT: assert property (@(posedge clk) disable iff (rst)
        $rose(drv_w) |-> (we_run >= RUN_W'(HZ_C)));                  // R3
    AST_DRIVE_NOT_READ: assert property (@(posedge clk) disable iff (rst)
        drv_w |-> (strb.sel && !strb.oe));                          // R3
    AST_WE_WIDTH: assert property (@(posedge clk) disable iff (rst)
        $fell(we_w) |-> (we_run >= RUN_W'(WP_C)));                   // R4
    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        $fell(we_w) |-> drv_w);                                     // R4

endmodule

// File: rtl/sram_dpath.sv
`timescale 1ns/1ps
module sram_dpath #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              sample,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] wr_byte,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mem_addr  <= '0;
            wr_byte   <= '0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            if (accept) begin
                mem_addr <= req_addr;
                wr_byte  <= req_wdata;
            end
            rsp_valid <= sample;
            if (sample)
                rsp_rdata <= mem_dq_in;
        end
    end

    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);                                  // R6

endmodule

// File: rtl/sram_async_ctl.sv
`timescale 1ns/1ps
module sram_async_ctl
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W    = 17,
    parameter int DATA_W    = 8,
    parameter int CLK_NS    = 4,
    parameter int T_WC_NS   = 55,
    parameter int T_WP_NS   = 40,
    parameter int T_CW_NS   = 40,
    parameter int T_DS_NS   = 25,
    parameter int T_HZWE_NS = 20,
    parameter int T_RC_NS   = 55,
    parameter int T_AA_NS   = 55,
    parameter int T_OE_NS   = 25
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_ce,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    strobe_t strb;
    logic    accept, sample;

    sram_seq #(
        .CLK_NS    (CLK_NS),
        .T_WC_NS   (T_WC_NS),
        .T_WP_NS   (T_WP_NS),
        .T_CW_NS   (T_CW_NS),
        .T_DS_NS   (T_DS_NS),
        .T_HZWE_NS (T_HZWE_NS),
        .T_RC_NS   (T_RC_NS),
        .T_AA_NS   (T_AA_NS),
        .T_OE_NS   (T_OE_NS)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_ready (req_ready),
        .accept    (accept),
        .sample    (sample),
        .strb      (strb)
    );

    sram_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .sample    (sample),
        .mem_dq_in (mem_dq_in),
        .mem_addr  (mem_addr),
        .wr_byte   (mem_dq_out),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    assign mem_ce_n  = ~strb.sel;
    assign mem_ce    =  strb.sel;
    assign mem_we_n  = ~strb.we;
    assign mem_oe_n  = ~strb.oe;
    assign mem_dq_oe =  strb.drv;

    logic pin_sel;
    assign pin_sel = !mem_ce_n && mem_ce;

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (pin_sel && $past(pin_sel)) |-> $stable(mem_addr));         // R2
    AST_OE_HIGH_IN_WRITE: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> (mem_oe_n && pin_sel));                       // R2
    AST_SEL_BEFORE_WE: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_we_n) |-> $past(pin_sel));                        // R2

endmodule

// File: tb/sram_async_ctl_tb.sv
`timescale 1ns/1ps
module sram_async_ctl_tb;

    localparam int CLK_NS   = 4;
    localparam int EXP_BUSY = 14;   // ceil(55/4) for both directions at this clock
    localparam int WDOG     = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [16:0] req_addr  = '0;
    logic [7:0]  req_wdata = '0;
    logic        rsp_valid;
    logic [7:0]  rsp_rdata;
    logic [16:0] mem_addr;
    logic        mem_ce_n, mem_ce, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [7:0]  mem_dq_out;
    logic [7:0]  dq_in_r = 8'hEE;

    int errors = 0;
    int checks = 0;
    int viol   = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    sram_async_ctl u_dut (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata),
        .mem_addr   (mem_addr),
        .mem_ce_n   (mem_ce_n),
        .mem_ce     (mem_ce),
        .mem_we_n   (mem_we_n),
        .mem_oe_n   (mem_oe_n),
        .mem_dq_out (mem_dq_out),
        .mem_dq_oe  (mem_dq_oe),
        .mem_dq_in  (dq_in_r)
    );

    // ---------------- behavioural RAM model ----------------
    logic [7:0] model_mem [int];
    logic [7:0] exp_mem   [int];
    int we_run = 0, drv_run = 0, acc_run = 0;
    bit prev_we_low = 1'b0, prev_oe = 1'b0;
    logic [16:0] acc_addr = '0;

    function automatic logic [7:0] mget(input logic [16:0] a);
        return model_mem.exists(int'(a)) ? model_mem[int'(a)] : 8'h00;
    endfunction

    always @(negedge clk) begin
        bit s;
        s = !mem_ce_n && mem_ce;
        if (rst) begin
            we_run = 0; drv_run = 0; acc_run = 0;
            prev_we_low = 1'b0; prev_oe = 1'b0; dq_in_r = 8'hEE;
        end else begin
            if (mem_dq_oe && s && !mem_oe_n && mem_we_n) viol++;         // contention
            if (s && !mem_we_n && !mem_oe_n) viol++;                     // OE low in write
            if (mem_dq_oe && !prev_oe && (we_run * CLK_NS < 20)) viol++; // early drive
            if (prev_we_low && mem_we_n) begin
                if (we_run * CLK_NS < 40 || drv_run * CLK_NS < 25 || !mem_dq_oe) viol++;
                model_mem[int'(mem_addr)] = mem_dq_out;
            end
            if (s && !mem_we_n) begin
                we_run++;
                if (mem_dq_oe) drv_run++; else drv_run = 0;
            end else begin
                we_run = 0; drv_run = 0;
            end
            prev_we_low = s && !mem_we_n;
            prev_oe     = mem_dq_oe;
            if (s && !mem_oe_n && mem_we_n) begin
                if (acc_run > 0 && mem_addr != acc_addr) acc_run = 0;
                acc_run++;
                acc_addr = mem_addr;
                dq_in_r  = (acc_run * CLK_NS >= 55) ? mget(mem_addr) : ~mget(mem_addr);
            end else begin
                acc_run = 0;
                dq_in_r = 8'hEE;
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic wr, input logic [16:0] a, input logic [7:0] d,
                          output int sel_at, output int busy,
                          output logic got_rsp, output logic [7:0] rd, output int early_rsp);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        sel_at = 0; busy = 0; early_rsp = 0;
        for (int k = 1; k < 1000; k++) begin
            if (req_ready) break;
            if (sel_at == 0 && !mem_ce_n && mem_ce) sel_at = k;
            if (rsp_valid) early_rsp++;
            busy++;
            @(negedge clk);
        end
        got_rsp = rsp_valid;
        rd      = rsp_rdata;
        if (wr) exp_mem[int'(a)] = d;
    endtask

    // {write, addr, data, expected selection cycle}
    localparam logic [27:0] VEC [12] = '{
        {1'b1, 17'h00000, 8'h3C, 2'd1},
        {1'b1, 17'h1FFFF, 8'hC3, 2'd1},
        {1'b0, 17'h00000, 8'h3C, 2'd2},
        {1'b0, 17'h1FFFF, 8'hC3, 2'd1},
        {1'b1, 17'h0AAAA, 8'h5A, 2'd2},
        {1'b1, 17'h15555, 8'hA5, 2'd1},
        {1'b0, 17'h0AAAA, 8'h5A, 2'd2},
        {1'b0, 17'h15555, 8'hA5, 2'd1},
        {1'b1, 17'h00001, 8'hFF, 2'd2},
        {1'b0, 17'h00001, 8'hFF, 2'd2},
        {1'b1, 17'h00000, 8'h00, 2'd2},
        {1'b0, 17'h00000, 8'h00, 2'd2}
    };

    initial begin
        int sel_at, busy, early;
        logic got;
        logic [7:0] rd;
        logic [16:0] ra [16];

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: outputs during reset
        chk("R9 ready in reset", req_ready, 1);
        chk("R9 rsp_valid in reset", rsp_valid, 0);
        chk("R9 strobes in reset", {mem_ce_n, mem_ce, mem_we_n, mem_oe_n, mem_dq_oe}, 5'b10110);
        rst = 1'b0;
        // R8 / R1: idle with no request stays in standby
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk("R8 idle ready", req_ready, 1);
            chk("R1 idle standby", {mem_ce_n, mem_ce}, 2'b10);
        end

        for (int i = 0; i < 12; i++) begin
            logic       vw;
            logic [16:0] va;
            logic [7:0] vd;
            int         vg;
            vw = VEC[i][27]; va = VEC[i][26:10]; vd = VEC[i][9:2]; vg = int'(VEC[i][1:0]);
            run_op(vw, va, vd, sel_at, busy, got, rd, early);
            chk("R7 selection cycle", sel_at, vg);
            if (vw) chk("R5 write busy cycles", busy, EXP_BUSY + vg - 1);
            else    chk("R6 read busy cycles", busy, EXP_BUSY + vg - 1);
            chk("R6 response only for reads", got, !vw);
            chk("R6 no early response", early, 0);
            if (!vw) chk("R6 read byte", rd, vd);
            chk("R1 standby when ready", {mem_ce_n, mem_ce}, 2'b10);
        end

        // R10: random addresses, write all then read back
        for (int i = 0; i < 16; i++) begin
            ra[i] = {i[3:0], 13'($urandom)};
            run_op(1'b1, ra[i], 8'($urandom), sel_at, busy, got, rd, early);
        end
        for (int i = 15; i >= 0; i--) begin
            run_op(1'b0, ra[i], 8'h00, sel_at, busy, got, rd, early);
            chk("R10 read after write", rd, exp_mem[int'(ra[i])]);
        end

        // R3 / R4 / R2: timing seen by the RAM model over the whole run
        chk("R3 R4 R2 model timing violations", viol, 0);

        // R9: reset again from idle
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R9 reset from idle", {req_ready, rsp_valid, mem_ce_n, mem_ce, mem_we_n, mem_oe_n, mem_dq_oe},
            7'b1010110);
        rst = 1'b0;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (cyc = 0; cyc < WDOG; cyc++) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule